// File: doc/BRIEF.md
# Interrupt line protocol checker

This block is a synthesizable monitor placed beside a block that drives one level-sensitive interrupt line. It watches a set of per-source trigger pulses, the interrupt line, the block's source-status vector and a clear strobe that carries a source number. From these it decides whether the line behaves as required.

Every trigger is stored as an expectation tagged with its source. Every rising edge of the line is matched against the oldest stored expectation. The check runs in both directions. A trigger that never produces an interrupt is flagged. An interrupt edge that no stored trigger accounts for is also flagged.

The monitor also flags a wrong reported source, a line that falls before it is cleared, a line or status bit that stays up after a clear, and an expectation store that overflows. All flags are sticky. A count of matched interrupts lets a test tell a quiet pass apart from a run in which nothing was checked.

Top module: `irq_line_monitor`

## Requirements
- R1: After a trigger is sampled at clock edge t, the line must be sampled high at edge t+1, t+2 or t+3. If it is still low at t+3, `err_missed_o` is set and that expectation is discarded.
- R2: A rise of the line while no expectation is pending sets `err_spurious_o`. This includes a rise sampled at the same edge as the only trigger, and a rise after earlier interrupts were all correct.
- R3: Once an interrupt is matched, the line must stay high until a clear is sampled. A low sample of the line before that sets `err_drop_o`.
- R4: After a clear for source c is sampled at edge k, two conditions must both hold by edge k+1, k+2 or k+3: the line is low, and bit c of the status vector is zero. If they do not, `err_stuck_o` is set.
- R5: At a matched rise, the reported source is the lowest-index set bit of the status vector. It must equal the source of the oldest pending expectation. If it does not, or if no status bit is set, `err_source_o` is set.
- R6: Triggers sampled at the same edge are queued lowest source index first, so source 0 has the highest priority. Interrupts must then be reported in that order.
- R7: When `eot_i` is sampled, any expectation still pending after that edge's own match or discard sets `err_missed_o`.
- R8: The queue holds 8 expectations. A trigger that finds the queue full sets `err_overflow_o` and is dropped. Exactly 8 simultaneous triggers into an empty queue do not overflow.
- R9: After reset all flags read 0 and the count reads 0. Every flag, once set, stays set until the next reset.
- R10: `match_cnt_o` increments by one on each rise that is matched to an expectation.
- R11: Expectations queued while an interrupt is being served do not age. The next expectation's 1-to-3-edge window starts after the edge at which the clear completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_i | input | 8 | One single-cycle trigger pulse per source |
| irq_i | input | 1 | Observed interrupt line |
| status_i | input | 8 | Observed source-status vector, one bit per source |
| clr_i | input | 1 | Clear strobe |
| clr_src_i | input | 3 | Source number carried by the clear strobe |
| eot_i | input | 1 | End-of-test pulse |
| err_spurious_o | output | 1 | Sticky: rise with no pending expectation |
| err_missed_o | output | 1 | Sticky: trigger not followed by an interrupt |
| err_source_o | output | 1 | Sticky: reported source does not match the expected source |
| err_drop_o | output | 1 | Sticky: line fell before a clear |
| err_stuck_o | output | 1 | Sticky: line or status bit still set after a clear |
| err_overflow_o | output | 1 | Sticky: trigger dropped on a full queue |
| match_cnt_o | output | 16 | Saturating count of matched interrupts |

## Verification
The bench builds the monitor with its defaults: 8 sources, an 8-entry queue and a 3-edge window. With these values it can sweep every source at every legal rise delay, and every legal drain delay one step past each edge. Eight sources into eight slots make the exact full boundary and the first overflow reachable in two cycles. Three-way simultaneous triggers, triggers arriving during service and end-of-test with a pending entry exercise the ordering and window-restart rules.

// File: rtl/irqmon_pkg.sv
package irqmon_pkg;

  // Tracking phase of the line as seen by the monitor
  typedef enum logic [1:0] {
    MON_IDLE    = 2'd0,  // line expected low, head expectation ageing
    MON_SERVE   = 2'd1,  // matched interrupt held high, awaiting clear
    MON_DRAIN   = 2'd2,  // clear seen, awaiting line low and status bit low
    MON_WAITLOW = 2'd3   // unaccounted-for high level, waiting for it to end
  } mon_state_e;

  typedef struct packed {
    logic overflow;
    logic stuck;
    logic drop;
    logic source;
    logic missed;
    logic spurious;
  } mon_err_t;

endpackage

// File: rtl/irqmon_prienc.sv
module irqmon_prienc #(
  parameter  int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // Lowest set index wins: scan from the top so the lowest index is written last
  always_comb begin
    idx_o = '0;
    any_o = |vec_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqmon_queue.sv
module irqmon_queue #(
  parameter  int NUM_SRC = 8,
  parameter  int DEPTH   = 8,   // power of two
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int QCNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] push_vec_i,
  input  logic               pop_i,
  output logic [SRC_W-1:0]   head_src_o,
  output logic               head_vld_o,
  output logic [QCNT_W-1:0]  cnt_o,
  output logic               drop_o
);

  logic [SRC_W-1:0]  slot_q [DEPTH];
  logic [SRC_W-1:0]  slot_d [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [QCNT_W-1:0] cnt_q, cnt_d, cnt_pop;
  logic              do_pop;
  logic              slot_en;
  int                n_push;

  // Next state: pop first, then place pushes lowest source first
  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    cnt_pop = cnt_q - QCNT_W'(do_pop);
    rd_d    = rd_q + PTR_W'(do_pop);
    slot_d  = slot_q;
    drop_o  = 1'b0;
    n_push  = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (push_vec_i[i]) begin
        if (int'(cnt_pop) + n_push < DEPTH) begin
          slot_d[wr_q + PTR_W'(n_push)] = SRC_W'(i);
          n_push = n_push + 1;
        end else begin
          drop_o = 1'b1;
        end
      end
    end
    wr_d    = wr_q + PTR_W'(n_push);
    cnt_d   = cnt_pop + QCNT_W'(n_push);
    slot_en = |push_vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (slot_en) slot_q <= slot_d;
  end

  assign head_src_o = slot_q[rd_q];
  assign head_vld_o = (cnt_q != '0);
  assign cnt_o      = cnt_q;

  // R8: a dropped trigger means the queue was filled to the brim
  assert_full_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> (cnt_q == QCNT_W'(DEPTH)));

endmodule

// File: rtl/irqmon_seq.sv
module irqmon_seq
  import irqmon_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  parameter  int WIN_MAX = 3,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int AGE_W   = $clog2(WIN_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_src_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               head_vld_i,
  input  logic [SRC_W-1:0]   head_src_i,
  input  logic [SRC_W-1:0]   rep_src_i,
  input  logic               rep_any_i,
  output logic               pop_o,
  output logic               match_o,
  output logic               spur_o,
  output logic               miss_o,
  output logic               src_err_o,
  output logic               drop_o,
  output logic               stuck_o
);

  localparam logic [AGE_W-1:0] LAST = AGE_W'(WIN_MAX - 1);

  mon_state_e       st_q, st_d;
  logic [AGE_W-1:0] age_q, age_d, dcnt_q, dcnt_d;
  logic [SRC_W-1:0] csrc_q;
  logic             age_en, dcnt_en, csrc_en;

  always_comb begin
    st_d      = st_q;
    age_d     = age_q;
    dcnt_d    = dcnt_q;
    pop_o     = 1'b0;
    match_o   = 1'b0;
    spur_o    = 1'b0;
    miss_o    = 1'b0;
    src_err_o = 1'b0;
    drop_o    = 1'b0;
    stuck_o   = 1'b0;
    age_en    = (st_q == MON_IDLE);
    dcnt_en   = (st_q == MON_SERVE) || (st_q == MON_DRAIN);
    csrc_en   = (st_q == MON_SERVE) && irq_i && clr_i;
    unique case (st_q)
      MON_IDLE: begin
        if (irq_i) begin
          age_d = '0;
          if (head_vld_i) begin
            pop_o     = 1'b1;
            match_o   = 1'b1;
            src_err_o = !(rep_any_i && (rep_src_i == head_src_i));
            st_d      = MON_SERVE;
          end else begin
            spur_o = 1'b1;
            st_d   = MON_WAITLOW;
          end
        end else if (head_vld_i) begin
          if (age_q == LAST) begin
            miss_o = 1'b1;
            pop_o  = 1'b1;
            age_d  = '0;
          end else begin
            age_d = age_q + AGE_W'(1);
          end
        end else begin
          age_d = '0;
        end
      end
      MON_SERVE: begin
        dcnt_d = '0;
        if (!irq_i) begin
          drop_o = 1'b1;
          st_d   = MON_IDLE;
        end else if (clr_i) begin
          st_d = MON_DRAIN;
        end
      end
      MON_DRAIN: begin
        if (!irq_i && !status_i[csrc_q]) begin
          st_d = MON_IDLE;
        end else if (dcnt_q == LAST) begin
          stuck_o = 1'b1;
          st_d    = MON_WAITLOW;
        end else begin
          dcnt_d = dcnt_q + AGE_W'(1);
        end
      end
      default: begin
        if (!irq_i) st_d = MON_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MON_IDLE;
      age_q  <= '0;
      dcnt_q <= '0;
      csrc_q <= '0;
    end else begin
      st_q <= st_d;
      if (age_en)  age_q  <= age_d;
      if (dcnt_en) dcnt_q <= dcnt_d;
      if (csrc_en) csrc_q <= clr_src_i;
    end
  end

  // R3: the serve phase is only ever occupied after a high sample of the line
  assert_serve_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MON_SERVE) |-> $past(irq_i));

  // R4: entering the drain phase requires a clear on the previous edge
  assert_drain_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MON_DRAIN) && ($past(st_q) != MON_DRAIN)) |-> $past(clr_i));

  // R1: a miss is only declared while the line is observed low
  assert_miss_line_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> !irq_i);

endmodule

// File: rtl/irq_line_monitor.sv
module irq_line_monitor
  import irqmon_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  parameter  int DEPTH   = 8,
  parameter  int WIN_MAX = 3,
  parameter  int CNT_W   = 16,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int QCNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               irq_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_src_i,
  input  logic               eot_i,
  output logic               err_spurious_o,
  output logic               err_missed_o,
  output logic               err_source_o,
  output logic               err_drop_o,
  output logic               err_stuck_o,
  output logic               err_overflow_o,
  output logic [CNT_W-1:0]   match_cnt_o
);

  logic [SRC_W-1:0]  rep_src, head_src;
  logic              rep_any, head_vld, q_pop, q_drop;
  logic [QCNT_W-1:0] q_cnt, q_left;
  logic              s_match, s_spur, s_miss, s_src, s_drop, s_stuck, eot_miss;
  mon_err_t          err_q, err_d;
  logic [CNT_W-1:0]  match_cnt_q, match_cnt_d;
  logic              cnt_en;

  irqmon_prienc #(.N(NUM_SRC)) u_report (
    .vec_i (status_i),
    .idx_o (rep_src),
    .any_o (rep_any)
  );

  irqmon_queue #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_vec_i (trig_i),
    .pop_i      (q_pop),
    .head_src_o (head_src),
    .head_vld_o (head_vld),
    .cnt_o      (q_cnt),
    .drop_o     (q_drop)
  );

  irqmon_seq #(.NUM_SRC(NUM_SRC), .WIN_MAX(WIN_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .clr_i      (clr_i),
    .clr_src_i  (clr_src_i),
    .status_i   (status_i),
    .head_vld_i (head_vld),
    .head_src_i (head_src),
    .rep_src_i  (rep_src),
    .rep_any_i  (rep_any),
    .pop_o      (q_pop),
    .match_o    (s_match),
    .spur_o     (s_spur),
    .miss_o     (s_miss),
    .src_err_o  (s_src),
    .drop_o     (s_drop),
    .stuck_o    (s_stuck)
  );

  // Entries left after this edge's own match or discard
  always_comb begin
    q_left   = q_cnt - QCNT_W'(q_pop);
    eot_miss = eot_i && (q_left != '0);

    err_d.spurious = err_q.spurious | s_spur;
    err_d.missed   = err_q.missed   | s_miss | eot_miss;
    err_d.source   = err_q.source   | s_src;
    err_d.drop     = err_q.drop     | s_drop;
    err_d.stuck    = err_q.stuck    | s_stuck;
    err_d.overflow = err_q.overflow | q_drop;

    cnt_en      = s_match && (match_cnt_q != '1);
    match_cnt_d = match_cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q       <= '0;
      match_cnt_q <= '0;
    end else begin
      err_q <= err_d;
      if (cnt_en) match_cnt_q <= match_cnt_d;
    end
  end

  assign err_spurious_o = err_q.spurious;
  assign err_missed_o   = err_q.missed;
  assign err_source_o   = err_q.source;
  assign err_drop_o     = err_q.drop;
  assign err_stuck_o    = err_q.stuck;
  assign err_overflow_o = err_q.overflow;
  assign match_cnt_o    = match_cnt_q;

  // R9: no flag ever falls back once raised
  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R10: the count only moves after a high sample of the line
  assert_count_needs_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_cnt_q != $past(match_cnt_q)) |-> $past(irq_i));

  // R6: the sequencer only consumes an expectation the queue actually holds
  assert_pop_has_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> head_vld);

endmodule

// File: tb/tb_irq_line_monitor.sv
`timescale 1ns/1ps
module tb_irq_line_monitor;

  localparam int CLK_PERIOD = 4;
  // flag vector bit positions: {overflow, stuck, drop, source, missed, spurious}
  localparam logic [5:0] F_NONE = 6'b000000;
  localparam logic [5:0] F_SPUR = 6'b000001;
  localparam logic [5:0] F_MISS = 6'b000010;
  localparam logic [5:0] F_SRC  = 6'b000100;
  localparam logic [5:0] F_DROP = 6'b001000;
  localparam logic [5:0] F_STCK = 6'b010000;

  logic       clk;
  logic       rst_n;
  logic [7:0] trig;
  logic       irq;
  logic [7:0] status;
  logic       clr;
  logic [2:0] clr_src;
  logic       eot;
  logic       e_spur, e_miss, e_src, e_drop, e_stuck, e_ovf;
  logic [15:0] mcnt;

  int total = 0;
  int bad   = 0;

  irq_line_monitor dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_i         (trig),
    .irq_i          (irq),
    .status_i       (status),
    .clr_i          (clr),
    .clr_src_i      (clr_src),
    .eot_i          (eot),
    .err_spurious_o (e_spur),
    .err_missed_o   (e_miss),
    .err_source_o   (e_src),
    .err_drop_o     (e_drop),
    .err_stuck_o    (e_stuck),
    .err_overflow_o (e_ovf),
    .match_cnt_o    (mcnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [5:0] flags();
    return {e_ovf, e_stuck, e_drop, e_src, e_miss, e_spur};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig = '0; irq = 1'b0; status = '0;
    clr = 1'b0; clr_src = '0; eot = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic trig_pulse(input logic [7:0] v);
    trig = v;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic raise(input logic [7:0] st);
    irq = 1'b1;
    status = st;
    @(negedge clk);
  endtask

  // rise, hold, clear, then drop the line k edges after the clear edge
  task automatic service(input int src, input logic [7:0] st_during, input int hold,
                         input int k, input logic [7:0] st_after);
    raise(st_during);
    repeat (hold) @(negedge clk);
    clr = 1'b1;
    clr_src = 3'(src);
    @(negedge clk);
    clr = 1'b0;
    repeat (k - 1) @(negedge clk);
    irq = 1'b0;
    status = st_after;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; trig = '0; irq = 1'b0; status = '0;
    clr = 1'b0; clr_src = '0; eot = 1'b0;

    // R9: reset state
    do_reset();
    chk("R9 reset flags", int'(flags()), int'(F_NONE));
    chk("R9 reset count", int'(mcnt), 0);

    // R1/R10: every source at every legal rise delay
    for (int s = 0; s < 8; s++) begin
      for (int d = 1; d <= 3; d++) begin
        trig_pulse(8'(1 << s));
        repeat (d - 1) @(negedge clk);
        service(s, 8'(1 << s), 1, 1, 8'h00);
        chk($sformatf("R1 src=%0d delay=%0d", s, d), int'(flags()), int'(F_NONE));
      end
    end
    chk("R10 matched count after sweep", int'(mcnt), 24);

    // R1: window boundary
    do_reset();
    trig_pulse(8'h08);
    repeat (2) @(negedge clk);
    chk("R1 no miss before window end", int'(flags()), int'(F_NONE));
    @(negedge clk);
    chk("R1 miss at window end", int'(flags()), int'(F_MISS));

    // R4: drain delay sweep
    do_reset();
    for (int k = 1; k <= 3; k++) begin
      trig_pulse(8'h04);
      service(2, 8'h04, 0, k, 8'h00);
      chk($sformatf("R4 drain k=%0d", k), int'(flags()), int'(F_NONE));
    end
    trig_pulse(8'h04);
    service(2, 8'h04, 0, 4, 8'h00);
    chk("R4 line stuck after clear", int'(flags()), int'(F_STCK));

    // R4: status bit stays set although the line fell
    do_reset();
    trig_pulse(8'h20);
    service(5, 8'h20, 0, 1, 8'h20);
    repeat (3) @(negedge clk);
    chk("R4 status bit stuck", int'(flags()), int'(F_STCK));
    status = '0;

    // R2: rise with nothing pending
    do_reset();
    raise(8'h00);
    chk("R2 spurious on idle", int'(flags()), int'(F_SPUR));
    irq = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 spurious flag sticky", int'(flags()), int'(F_SPUR));
    do_reset();
    chk("R9 reset clears flags", int'(flags()), int'(F_NONE));

    // R2: spurious after a correct interrupt
    trig_pulse(8'h01);
    service(0, 8'h01, 1, 1, 8'h00);
    chk("R2 good interrupt first", int'(flags()), int'(F_NONE));
    raise(8'h01);
    chk("R2 spurious after good", int'(flags()), int'(F_SPUR));
    irq = 1'b0; status = '0;

    // R2: rise in the same cycle as the trigger is too early
    do_reset();
    trig = 8'h10; irq = 1'b1; status = 8'h10;
    @(negedge clk);
    trig = '0;
    chk("R2 same-cycle rise", int'(flags()), int'(F_SPUR));
    irq = 1'b0; status = '0;

    // R3: drop before clear
    do_reset();
    trig_pulse(8'h04);
    raise(8'h04);
    irq = 1'b0; status = '0;
    @(negedge clk);
    chk("R3 drop before clear", int'(flags()), int'(F_DROP));

    // R5: reported source
    do_reset();
    trig_pulse(8'h04);
    service(2, 8'h24, 0, 1, 8'h00);
    chk("R5 lowest status bit matches", int'(flags()), int'(F_NONE));
    trig_pulse(8'h04);
    service(2, 8'h20, 0, 1, 8'h00);
    chk("R5 wrong source", int'(flags()), int'(F_SRC));
    do_reset();
    trig_pulse(8'h04);
    service(2, 8'h06, 0, 1, 8'h00);
    chk("R5 higher-priority bit reported", int'(flags()), int'(F_SRC));
    do_reset();
    trig_pulse(8'h04);
    service(2, 8'h00, 0, 1, 8'h00);
    chk("R5 empty status", int'(flags()), int'(F_SRC));

    // R6: simultaneous triggers served lowest index first
    do_reset();
    trig_pulse(8'h52);
    service(1, 8'h52, 0, 1, 8'h50);
    service(4, 8'h50, 0, 1, 8'h40);
    service(6, 8'h40, 0, 1, 8'h00);
    chk("R6 priority order flags", int'(flags()), int'(F_NONE));
    chk("R6 priority order count", int'(mcnt), 3);
    do_reset();
    trig_pulse(8'h12);
    service(4, 8'h10, 0, 1, 8'h00);
    chk("R6 lower priority reported first", int'(flags()), int'(F_SRC));

    // R11: trigger during service, window restarts after clear completes
    for (int g = 3; g <= 4; g++) begin
      do_reset();
      trig_pulse(8'h01);
      raise(8'h01);
      trig = 8'h08;
      @(negedge clk);
      trig = '0;
      repeat (5) @(negedge clk);
      clr = 1'b1; clr_src = 3'd0;
      @(negedge clk);
      clr = 1'b0; irq = 1'b0; status = 8'h08;
      @(negedge clk);
      repeat (g - 1) @(negedge clk);
      if (g == 3) begin
        service(3, 8'h08, 0, 1, 8'h00);
        chk("R11 queued source served in window", int'(flags()), int'(F_NONE));
        chk("R11 both matched", int'(mcnt), 2);
      end else begin
        chk("R11 queued source missed", int'(flags()), int'(F_MISS));
        status = '0;
      end
    end

    // R7: end of test
    do_reset();
    eot = 1'b1; @(negedge clk); eot = 1'b0;
    chk("R7 eot with empty queue", int'(flags()), int'(F_NONE));
    trig_pulse(8'h40);
    eot = 1'b1; @(negedge clk); eot = 1'b0;
    chk("R7 eot with pending", int'(flags()), int'(F_MISS));

    // R8: exact full then overflow
    do_reset();
    trig_pulse(8'hFF);
    chk("R8 eight fit", int'(e_ovf), 0);
    trig_pulse(8'h01);
    chk("R8 ninth overflows", int'(e_ovf), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule